// File: doc/BRIEF.md
# Fixed-Priority Multi-Target Bus Crossbar

This block joins five bus masters to five targets. Each master presents a request with an address, a write flag, write data and a burst length. The top bits of the address pick the target. Masters that want different targets are served side by side in the same cycle. Each target has its own arbiter. When several masters want the same idle target, that arbiter picks one from its own fixed ranking. The winner then owns the target until every beat of its burst has been accepted. The other masters wait with no grant and no acknowledge.

The ranking is a parameter with one ordered list per target. A master can therefore be last in line at one target and first at another. An address that selects no target is answered at once with an error flag, and no target is claimed. Clock-crossing logic and the targets themselves sit outside this block.

Top module: `xbar_fixed_prio`

## Requirements
- R1: Address bits [AW-1:AW-4] give the target number. Values 0 to 4 select targets 0 to 4. Any value from 5 to 15 raises `m_err` for that master in the same cycle as the request. It never raises `m_gnt` and it drives no `t_req`.
- R2: After reset no target is owned, and `m_gnt`, `m_ack`, `m_err` and `t_req` are all low.
- R3: A request to an idle target that wins arbitration shows `m_gnt` and `t_req` high in the cycle that follows the first request cycle.
- R4: Requests to different targets that start in the same cycle are all granted in the same following cycle.
- R5: Masters that request one idle target are granted in the order that target's ranking gives, highest first. The rankings are: target 0: 0,2,3,4,1; target 1: 2,3,0,4,1; target 2: 0,2,3,4,1; target 3: 2,3,4,1,0; target 4: 4,2,3,0,1. Master 2 is always ahead of master 3, and master 1 is last at target 1.
- R6: An owner keeps its target for `m_len`+1 acknowledged beats. No other master is granted that target during this time, whatever its rank.
- R7: A target is idle for exactly one cycle after its last beat is acknowledged. A master that is waiting at that moment is granted in the next cycle, and the choice is made by rank among the masters waiting then, not by the order in which they arrived.
- R8: While a target is owned, `t_addr`, `t_we` and `t_wdata` of that target equal the owner's address, write flag and write data. The owner's `m_rdata` equals the target's `t_rdata`.
- R9: `m_ack` is high only for the owner, and only in cycles where the target's `t_rdy` is high. A waiting master sees neither `m_gnt` nor `m_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req | input | N_MST | Request from each master, held high until its last beat is acknowledged |
| m_we | input | N_MST | Write flag from each master |
| m_addr | input | N_MST*AW | Address from each master; the top SELW bits select the target |
| m_wdata | input | N_MST*DW | Write data from each master, one beat at a time |
| m_len | input | N_MST*LENW | Burst length minus one, per master |
| m_gnt | output | N_MST | Master owns its addressed target |
| m_ack | output | N_MST | Beat accepted at the coming clock edge |
| m_err | output | N_MST | Address selects no target |
| m_rdata | output | N_MST*DW | Read data routed back from the owned target |
| t_req | output | N_TGT | Beat valid toward each target |
| t_we | output | N_TGT | Owner's write flag per target |
| t_addr | output | N_TGT*AW | Owner's address per target |
| t_wdata | output | N_TGT*DW | Owner's write data per target |
| t_rdy | input | N_TGT | Target accepts the current beat |
| t_rdata | input | N_TGT*DW | Read data from each target |

## Verification
The bench first drives one master alone, which shows the one-cycle grant latency. It then drives four masters to four different targets at once, and a shared cycle of grants shows that the arbiters run independently. Groups of masters that start together at targets 1, 2 and 3 must come out in each target's own order, and their grant cycles, spaced by burst length plus two, show that ownership is held and then released. A late arrival test checks that a higher-ranked waiter overtakes an earlier lower-ranked one. Tests with a stalled target and with an undecodable address check acknowledge gating, routing toward the target and the error path.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic {
    ARB_IDLE   = 1'b0,
    ARB_LOCKED = 1'b1
  } arb_state_e;

  // target select field maps to a real target only below the target count
  function automatic logic sel_valid(input logic [31:0] sel, input int unsigned n_tgt);
    return sel < n_tgt;
  endfunction

  // remaining-beat counter holds beats minus one; zero marks the final beat
  function automatic logic final_beat(input logic [31:0] left);
    return left == 32'd0;
  endfunction

endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec #(
  parameter int AW    = 32,
  parameter int SELW  = 4,
  parameter int N_TGT = 5,
  parameter int TW    = 3
) (
  input  logic          req,
  input  logic [AW-1:0] addr,
  output logic [TW-1:0] tgt,
  output logic          hit,
  output logic          miss
);
  import xbar_pkg::*;

  logic [SELW-1:0] sel;

  assign sel  = addr[AW-1 -: SELW];
  assign hit  = sel_valid(32'(sel), N_TGT);
  assign tgt  = hit ? sel[TW-1:0] : '0;
  assign miss = req && !hit;

endmodule

// File: rtl/xbar_tgt_arb.sv
module xbar_tgt_arb #(
  parameter int N_MST = 5,
  parameter int LENW  = 4,
  parameter int IW    = 3,
  parameter logic [N_MST*IW-1:0] ORDER = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_MST-1:0]      want,
  input  logic [N_MST*LENW-1:0] len_all,
  input  logic                  rdy,
  output logic                  locked,
  output logic [IW-1:0]         owner,
  output logic                  grant_evt,
  output logic                  beat_ack,
  output logic                  release_evt
);
  import xbar_pkg::*;

  arb_state_e      state;
  logic [LENW-1:0] left;
  logic [IW-1:0]   winner;
  logic            found;

  // walk the ranking from highest to lowest and keep the first requester
  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int k = 0; k < N_MST; k++) begin
      if (!found && want[ORDER[k*IW +: IW]]) begin
        found  = 1'b1;
        winner = ORDER[k*IW +: IW];
      end
    end
  end

  assign locked      = (state == ARB_LOCKED);
  assign grant_evt   = !locked && found;
  assign beat_ack    = locked && want[owner] && rdy;
  assign release_evt = beat_ack && final_beat(32'(left));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ARB_IDLE;
      owner <= '0;
      left  <= '0;
    end else if (grant_evt) begin
      state <= ARB_LOCKED;
      owner <= winner;
      left  <= len_all[winner*LENW +: LENW];
    end else if (release_evt) begin
      state <= ARB_IDLE;
    end else if (beat_ack) begin
      left <= left - 1'b1;
    end
  end

endmodule

// File: rtl/xbar_mst_port.sv
module xbar_mst_port #(
  parameter int MY_ID = 0,
  parameter int N_TGT = 5,
  parameter int TW    = 3,
  parameter int IW    = 3,
  parameter int DW    = 32
) (
  input  logic                req,
  input  logic                hit,
  input  logic                miss,
  input  logic [TW-1:0]       tgt,
  input  logic [N_TGT-1:0]    tgt_locked,
  input  logic [N_TGT*IW-1:0] tgt_owner,
  input  logic [N_TGT-1:0]    t_rdy,
  input  logic [N_TGT*DW-1:0] t_rdata,
  output logic                gnt,
  output logic                ack,
  output logic [DW-1:0]       rdata,
  output logic                err
);

  logic [IW-1:0] owner_here;

  assign owner_here = tgt_owner[tgt*IW +: IW];
  assign gnt        = hit && tgt_locked[tgt] && (owner_here == IW'(MY_ID));
  assign ack        = gnt && req && t_rdy[tgt];
  assign rdata      = gnt ? t_rdata[tgt*DW +: DW] : '0;
  assign err        = miss;

endmodule

// File: rtl/xbar_fixed_prio.sv
module xbar_fixed_prio #(
  parameter int N_MST = 5,
  parameter int N_TGT = 5,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LENW  = 4,
  parameter int SELW  = 4,
  parameter int IW    = $clog2(N_MST),
  parameter int TW    = $clog2(N_TGT),
  // entry for target t, rank k (0 = highest) sits at bits [(t*N_MST+k)*IW +: IW]
  parameter logic [N_TGT*N_MST*IW-1:0] PRIO = {
    3'd1, 3'd0, 3'd3, 3'd2, 3'd4,
    3'd0, 3'd1, 3'd4, 3'd3, 3'd2,
    3'd1, 3'd4, 3'd3, 3'd2, 3'd0,
    3'd1, 3'd4, 3'd0, 3'd3, 3'd2,
    3'd1, 3'd4, 3'd3, 3'd2, 3'd0
  }
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_MST-1:0]       m_req,
  input  logic [N_MST-1:0]       m_we,
  input  logic [N_MST*AW-1:0]    m_addr,
  input  logic [N_MST*DW-1:0]    m_wdata,
  input  logic [N_MST*LENW-1:0]  m_len,
  output logic [N_MST-1:0]       m_gnt,
  output logic [N_MST-1:0]       m_ack,
  output logic [N_MST-1:0]       m_err,
  output logic [N_MST*DW-1:0]    m_rdata,
  output logic [N_TGT-1:0]       t_req,
  output logic [N_TGT-1:0]       t_we,
  output logic [N_TGT*AW-1:0]    t_addr,
  output logic [N_TGT*DW-1:0]    t_wdata,
  input  logic [N_TGT-1:0]       t_rdy,
  input  logic [N_TGT*DW-1:0]    t_rdata
);

  localparam int ORDW = N_MST * IW;

  logic [TW-1:0]       m_tgt [N_MST];
  logic [N_MST-1:0]    m_hit;
  logic [N_MST-1:0]    m_miss;
  logic [N_MST-1:0]    want  [N_TGT];
  logic [N_TGT-1:0]    tgt_locked;
  logic [N_TGT*IW-1:0] owner_flat;
  logic [N_TGT-1:0]    grant_evt;
  logic [N_TGT-1:0]    beat_ack;
  logic [N_TGT-1:0]    release_evt;

  // master side: decode and response routing
  for (genvar i = 0; i < N_MST; i++) begin : g_mst
    xbar_addr_dec #(
      .AW(AW), .SELW(SELW), .N_TGT(N_TGT), .TW(TW)
    ) u_dec (
      .req  (m_req[i]),
      .addr (m_addr[i*AW +: AW]),
      .tgt  (m_tgt[i]),
      .hit  (m_hit[i]),
      .miss (m_miss[i])
    );

    xbar_mst_port #(
      .MY_ID(i), .N_TGT(N_TGT), .TW(TW), .IW(IW), .DW(DW)
    ) u_port (
      .req        (m_req[i]),
      .hit        (m_hit[i]),
      .miss       (m_miss[i]),
      .tgt        (m_tgt[i]),
      .tgt_locked (tgt_locked),
      .tgt_owner  (owner_flat),
      .t_rdy      (t_rdy),
      .t_rdata    (t_rdata),
      .gnt        (m_gnt[i]),
      .ack        (m_ack[i]),
      .rdata      (m_rdata[i*DW +: DW]),
      .err        (m_err[i])
    );
  end

  // request matrix: which masters address which target
  always_comb begin
    for (int t = 0; t < N_TGT; t++) begin
      for (int i = 0; i < N_MST; i++) begin
        want[t][i] = m_req[i] && m_hit[i] && (m_tgt[i] == TW'(t));
      end
    end
  end

  // target side: one arbiter and one forward mux per target
  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    logic [IW-1:0] own;

    xbar_tgt_arb #(
      .N_MST(N_MST), .LENW(LENW), .IW(IW),
      .ORDER(PRIO[t*ORDW +: ORDW])
    ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .want        (want[t]),
      .len_all     (m_len),
      .rdy         (t_rdy[t]),
      .locked      (tgt_locked[t]),
      .owner       (own),
      .grant_evt   (grant_evt[t]),
      .beat_ack    (beat_ack[t]),
      .release_evt (release_evt[t])
    );

    assign owner_flat[t*IW +: IW] = own;
    assign t_req[t]               = tgt_locked[t] && m_req[own];
    assign t_we[t]                = tgt_locked[t] && m_we[own];
    assign t_addr[t*AW +: AW]     = tgt_locked[t] ? m_addr[own*AW +: AW] : '0;
    assign t_wdata[t*DW +: DW]    = tgt_locked[t] ? m_wdata[own*DW +: DW] : '0;
  end

endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
  parameter int N_MST = 5,
  parameter int N_TGT = 5,
  parameter int IW    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_MST-1:0]    m_gnt,
  input logic [N_MST-1:0]    m_ack,
  input logic [N_MST-1:0]    m_err,
  input logic [N_TGT-1:0]    t_req,
  input logic [N_TGT-1:0]    tgt_locked,
  input logic [N_TGT*IW-1:0] owner_flat,
  input logic [N_TGT-1:0]    grant_evt,
  input logic [N_TGT-1:0]    release_evt
);

  for (genvar i = 0; i < N_MST; i++) begin : g_m
    p_err_no_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[i] |-> (!m_gnt[i] && !m_ack[i]));

    p_ack_only_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      m_ack[i] |-> m_gnt[i]);
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_t
    p_grant_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_evt[t] |=> tgt_locked[t]);

    p_owner_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_locked[t] && !release_evt[t]) |=>
        (tgt_locked[t] && $stable(owner_flat[t*IW +: IW])));

    p_idle_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      release_evt[t] |=> !tgt_locked[t]);

    p_beat_needs_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
      t_req[t] |-> tgt_locked[t]);
  end

endmodule

bind xbar_fixed_prio xbar_chk #(
  .N_MST(N_MST), .N_TGT(N_TGT), .IW(IW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .m_gnt       (m_gnt),
  .m_ack       (m_ack),
  .m_err       (m_err),
  .t_req       (t_req),
  .tgt_locked  (tgt_locked),
  .owner_flat  (owner_flat),
  .grant_evt   (grant_evt),
  .release_evt (release_evt)
);

// File: tb/xbar_fixed_prio_test.sv
module xbar_fixed_prio_test;

  localparam int NM = 5;
  localparam int NT = 5;
  localparam int W  = 32;
  localparam int LW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NM-1:0]   m_req = '0;
  logic [NM-1:0]   m_we = '0;
  logic [NM*W-1:0] m_addr = '0;
  logic [NM*W-1:0] m_wdata = '0;
  logic [NM*LW-1:0] m_len = '0;
  logic [NM-1:0]   m_gnt, m_ack, m_err;
  logic [NM*W-1:0] m_rdata;
  logic [NT-1:0]   t_req, t_we;
  logic [NT*W-1:0] t_addr, t_wdata;
  logic [NT-1:0]   t_rdy = '1;
  logic [NT*W-1:0] t_rdata;

  always #2 clk = ~clk;  // 4 ns period

  xbar_fixed_prio uut (
    .clk(clk), .rst_n(rst_n),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_len(m_len),
    .m_gnt(m_gnt), .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
    .t_req(t_req), .t_we(t_we), .t_addr(t_addr), .t_wdata(t_wdata),
    .t_rdy(t_rdy), .t_rdata(t_rdata)
  );

  // target model: read data is address plus write data
  always_comb begin
    for (int t = 0; t < NT; t++)
      t_rdata[t*W +: W] = t_addr[t*W +: W] + t_wdata[t*W +: W];
  end

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  int gnt_cyc [NM];
  int start_cyc [NM];
  logic [NM-1:0] prev_gnt = '0;

  typedef struct { int m; logic [31:0] d; } exp_t;
  exp_t sbq [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // monitor: record first grant cycle, compare acknowledged beats with the scoreboard
  always @(negedge clk) begin
    for (int m = 0; m < NM; m++) begin
      if (m_gnt[m] && !prev_gnt[m] && gnt_cyc[m] < 0) gnt_cyc[m] = cyc;
      if (m_ack[m]) begin
        int idx;
        idx = -1;
        for (int q = 0; q < sbq.size(); q++)
          if (idx < 0 && sbq[q].m == m) idx = q;
        if (idx < 0) begin
          check(1'b0, "R8 unexpected beat ack", m, -1);
        end else begin
          check(m_rdata[m*W +: W] == sbq[idx].d, "R8 routed read data",
                m_rdata[m*W +: W], sbq[idx].d);
          sbq.delete(idx);
        end
      end
    end
    prev_gnt = m_gnt;
  end

  function automatic logic [31:0] mk_addr(input int tgt, input int m);
    return {4'(tgt), 28'(32'h0010_0000 * (m + 1) + 32'h40)};
  endfunction

  task automatic clear_log();
    for (int m = 0; m < NM; m++) begin
      gnt_cyc[m] = -1;
      start_cyc[m] = -1;
    end
  endtask

  // driver: pushes expected beats, then runs one burst as master m
  task automatic master_run(input int m, input int tgt, input int len,
                            input logic [31:0] wd, input bit we);
    logic [31:0] a;
    int beats;
    a = mk_addr(tgt, m);
    for (int b = 0; b <= len; b++) sbq.push_back('{m, a + wd + 32'(b)});
    @(posedge clk); #1;
    start_cyc[m] = cyc;
    m_req[m] = 1'b1;
    m_we[m] = we;
    m_addr[m*W +: W] = a;
    m_len[m*LW +: LW] = LW'(len);
    m_wdata[m*W +: W] = wd;
    beats = 0;
    while (beats <= len) begin
      @(negedge clk);
      if (m_ack[m]) beats++;
      @(posedge clk); #1;
      if (beats > len) m_req[m] = 1'b0;
      else m_wdata[m*W +: W] = wd + 32'(beats);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      check(1'b0, "watchdog expired", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_log();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(t_req == '0, "R2 t_req idle after reset", t_req, 0);
    check(m_gnt == '0, "R2 m_gnt idle after reset", m_gnt, 0);
    check(m_ack == '0 && m_err == '0, "R2 ack/err idle after reset", {m_ack, m_err}, 0);

    // R3 single master latency
    clear_log();
    master_run(0, 2, 0, 32'h11, 1'b0);
    check(gnt_cyc[0] == start_cyc[0] + 1, "R3 grant one cycle after request",
          gnt_cyc[0], start_cyc[0] + 1);
    repeat (2) @(posedge clk);

    // R4 parallel access to four different targets
    clear_log();
    fork
      master_run(0, 0, 1, 32'h100, 1'b0);
      master_run(2, 1, 2, 32'h200, 1'b1);
      master_run(3, 3, 0, 32'h300, 1'b0);
      master_run(4, 4, 3, 32'h400, 1'b1);
    join
    check(gnt_cyc[0] == start_cyc[0] + 1, "R4 master0 parallel grant", gnt_cyc[0], start_cyc[0] + 1);
    check(gnt_cyc[2] == start_cyc[0] + 1, "R4 master2 parallel grant", gnt_cyc[2], start_cyc[0] + 1);
    check(gnt_cyc[3] == start_cyc[0] + 1, "R4 master3 parallel grant", gnt_cyc[3], start_cyc[0] + 1);
    check(gnt_cyc[4] == start_cyc[0] + 1, "R4 master4 parallel grant", gnt_cyc[4], start_cyc[0] + 1);
    repeat (2) @(posedge clk);

    // R5 R6 R7 target 2 ranking 0,2,3,4,1 with bursts
    clear_log();
    fork
      master_run(1, 2, 1, 32'h500, 1'b0);
      master_run(2, 2, 0, 32'h600, 1'b0);
      master_run(3, 2, 2, 32'h700, 1'b0);
    join
    check(gnt_cyc[2] == start_cyc[2] + 1, "R5 t2 first is master2", gnt_cyc[2], start_cyc[2] + 1);
    check(gnt_cyc[3] == gnt_cyc[2] + 2, "R6 t2 master3 after master2 burst", gnt_cyc[3], gnt_cyc[2] + 2);
    check(gnt_cyc[1] == gnt_cyc[3] + 4, "R7 t2 master1 after 3-beat burst + idle", gnt_cyc[1], gnt_cyc[3] + 4);
    repeat (2) @(posedge clk);

    // R5 target 1 ranking 2,3,0,4,1: fetch master last
    clear_log();
    fork
      master_run(0, 1, 0, 32'h800, 1'b0);
      master_run(1, 1, 0, 32'h900, 1'b0);
      master_run(3, 1, 0, 32'hA00, 1'b0);
      master_run(4, 1, 0, 32'hB00, 1'b0);
    join
    check(gnt_cyc[3] == start_cyc[3] + 1, "R5 t1 first is master3", gnt_cyc[3], start_cyc[3] + 1);
    check(gnt_cyc[0] == gnt_cyc[3] + 2, "R5 t1 second is master0", gnt_cyc[0], gnt_cyc[3] + 2);
    check(gnt_cyc[4] == gnt_cyc[0] + 2, "R5 t1 third is master4", gnt_cyc[4], gnt_cyc[0] + 2);
    check(gnt_cyc[1] == gnt_cyc[4] + 2, "R5 t1 master1 fifth", gnt_cyc[1], gnt_cyc[4] + 2);
    repeat (2) @(posedge clk);

    // R5 target 3 ranking 2,3,4,1,0: master1 now ahead of master0
    clear_log();
    fork
      master_run(0, 3, 0, 32'hC00, 1'b0);
      master_run(1, 3, 0, 32'hD00, 1'b0);
    join
    check(gnt_cyc[1] == start_cyc[1] + 1, "R5 t3 master1 first", gnt_cyc[1], start_cyc[1] + 1);
    check(gnt_cyc[0] == gnt_cyc[1] + 2, "R5 t3 master0 second", gnt_cyc[0], gnt_cyc[1] + 2);
    repeat (2) @(posedge clk);

    // R7 late arrivals at target 3: master4 waits first, master2 overtakes it
    clear_log();
    fork
      master_run(0, 3, 3, 32'hE00, 1'b1);
      begin repeat (2) @(posedge clk); master_run(4, 3, 0, 32'hF00, 1'b0); end
      begin repeat (3) @(posedge clk); master_run(2, 3, 0, 32'h1000, 1'b0); end
    join
    check(gnt_cyc[0] == start_cyc[0] + 1, "R6 t3 holder granted", gnt_cyc[0], start_cyc[0] + 1);
    check(gnt_cyc[2] == gnt_cyc[0] + 5, "R7 t3 higher-ranked late waiter next", gnt_cyc[2], gnt_cyc[0] + 5);
    check(gnt_cyc[4] == gnt_cyc[2] + 2, "R7 t3 earlier waiter after", gnt_cyc[4], gnt_cyc[2] + 2);
    repeat (2) @(posedge clk);

    // R8 R9 stalled target 4, ranking 4,2,3,0,1
    clear_log();
    @(posedge clk); #1 t_rdy[4] = 1'b0;
    fork
      master_run(2, 4, 1, 32'h2000, 1'b1);
      master_run(3, 4, 0, 32'h3000, 1'b0);
      begin
        repeat (4) @(negedge clk);
        check(m_gnt[2] == 1'b1, "R9 stalled owner holds grant", m_gnt[2], 1);
        check(m_ack[2] == 1'b0, "R9 no ack while t_rdy low", m_ack[2], 0);
        check(m_gnt[3] == 1'b0 && m_ack[3] == 1'b0, "R9 waiter stalled", {m_gnt[3], m_ack[3]}, 0);
        check(t_req[4] == 1'b1, "R8 beat presented to target", t_req[4], 1);
        check(t_addr[4*W +: W] == mk_addr(4, 2), "R8 owner address forwarded",
              t_addr[4*W +: W], mk_addr(4, 2));
        check(t_we[4] == 1'b1, "R8 owner write flag forwarded", t_we[4], 1);
        check(t_wdata[4*W +: W] == 32'h2000, "R8 owner write data forwarded",
              t_wdata[4*W +: W], 32'h2000);
        @(posedge clk); #1 t_rdy[4] = 1'b1;
      end
    join
    check(gnt_cyc[3] > gnt_cyc[2] + 4, "R6 waiter granted only after stalled burst", gnt_cyc[3], gnt_cyc[2] + 5);
    repeat (2) @(posedge clk);

    // R1 undecodable addresses
    @(posedge clk); #1;
    m_req[1] = 1'b1;
    m_addr[1*W +: W] = 32'h7000_0040;
    @(negedge clk);
    check(m_err[1] == 1'b1, "R1 error for select 7", m_err[1], 1);
    check(t_req == '0, "R1 no target beat for select 7", t_req, 0);
    @(posedge clk); #1 m_addr[1*W +: W] = 32'hF000_0000;
    @(negedge clk);
    check(m_err[1] == 1'b1, "R1 error for select 15", m_err[1], 1);
    check(m_gnt[1] == 1'b0 && t_req == '0, "R1 no lock for bad address", {m_gnt[1], t_req}, 0);
    @(posedge clk); #1 m_req[1] = 1'b0;
    @(negedge clk);
    check(m_err[1] == 1'b0, "R1 error clears with request", m_err[1], 0);

    repeat (3) @(posedge clk);
    check(sbq.size() == 0, "R8 every expected beat delivered", sbq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule